// File: doc/BRIEF.md
# Twin-Port Synchronous RAM with Read/Write Clash Alert

This block is a synchronous memory with two independent access ports, A and B, that share one clock. Each port registers its address, write data, write strobe, byte-lane enables and two chip enables on the rising edge. Through its own mode input, each port then returns read data after either a short (flow-through) latency or a long (pipelined) latency. Both ports may address any word in the same cycle. A port whose read hits the word that the other port is writing in that same cycle gets an active-low clash alert. The alert arrives together with the read data, and that data must be treated as untrustworthy.

The word is 36 bits wide and is split into four 9-bit byte lanes. Lane i occupies bits 9i+8 down to 9i, and each lane has its own enable bit. The depth is a parameter.

Each port's read path contains a small output state machine with three states. `RP_IDLE` means no pipelined result is pending. `RP_LIVE` means a pipelined result is on the outputs. `RP_TAIL` is the one cycle after the last pipelined result, in which the outputs are off again. The transitions are:
- idle-to-live: a read result enters the second stage.
- live-to-live: back-to-back reads.
- live-to-tail: no new read enters the second stage.
- tail-to-live: a read enters the second stage.
- tail-to-idle: no read enters the second stage.

Because of this machine, a pipelined port that is deselected still presents the read it already had in flight. This gives double-cycle deselect behaviour.

Top module: `twin_port_ram`

## Requirements
- R1: A port is selected only when its `ce0_n` is 0 and its `ce1` is 1. A deselected port neither writes the array nor produces read data.
- R2: A selected write (`wr`=1) updates exactly the lanes whose `be` bit is 1. Lane i is bits 9i+8:9i, and the other lanes keep their contents.
- R3: On a selected read, every lane whose `be` bit is 0 returns zeros. The enabled lanes return the stored bytes.
- R4: With `pipe`=0, a read sampled at edge k shows `rvalid`=1 and its data after edge k+1, and not after edge k.
- R5: With `pipe`=1, a read sampled at edge k shows `rvalid`=1 and its data after edge k+2. `rvalid` is 0 after edge k+1.
- R6: In pipelined mode, if the port is deselected at edge k+1 after a read at edge k, the read still appears after edge k+2. `rvalid` then falls after edge k+3.
- R7: Two reads of the same word in the same cycle both return the stored data, and neither port raises its alert.
- R8: When one port reads a word and the other port writes that word (any lane enabled) in the same cycle, the reader's `col_n` is 0 together with that read's `rvalid`. The writer's `col_n` stays 1, and different addresses raise no alert.
- R9: Two writes to the same word in the same cycle raise no alert on either port. The stored value is then unspecified.
- R10: Whenever `rvalid` is 0, `rdata` is all zeros and `col_n` is 1.
- R11: During and right after reset, both ports show `rvalid`=0, `col_n`=1 and `rdata`=0.
- R12: A write never produces `rvalid`=1 on its own port.
- R13: A read issued on one port one cycle after the other port's write to the same word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control and pipeline state |
| a_addr | input | AW | Port A word address |
| a_wdata | input | 36 | Port A write data |
| a_wr | input | 1 | Port A write strobe (1 = write, 0 = read) |
| a_be | input | 4 | Port A byte-lane enables, bit i for lane i |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_pipe | input | 1 | Port A read latency select (1 = pipelined) |
| a_rdata | output | 36 | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| a_col_n | output | 1 | Port A clash alert, active low |
| b_addr | input | AW | Port B word address |
| b_wdata | input | 36 | Port B write data |
| b_wr | input | 1 | Port B write strobe |
| b_be | input | 4 | Port B byte-lane enables |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_pipe | input | 1 | Port B read latency select |
| b_rdata | output | 36 | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |
| b_col_n | output | 1 | Port B clash alert, active low |

## Verification
The main function is tried with several kinds of access:
- Single-port full-word and partial-lane writes and reads separate lane masking from whole-word behaviour.
- Reads in both latency modes, including a deselect right after a pipelined read, separate one-stage from two-stage timing and expose the deselect tail.
- Same-cycle pairs across ports (read/read, read/write on the same and on different words, write/write) show whether the alert depends on the address match and on which side writes.
- A write followed one cycle later by a read on the other port shows that committed data is visible across ports.

// File: rtl/twin_port_ram_pkg.sv
package twin_port_ram_pkg;
    localparam int LANE_COUNT = 4;
    localparam int LANE_BITS  = 9;

    typedef enum logic [1:0] {
        RP_IDLE = 2'd0,
        RP_LIVE = 2'd1,
        RP_TAIL = 2'd2
    } rp_state_t;
endpackage

// File: rtl/tpr_array.sv
module tpr_array #(
    parameter int DEPTH  = 256,
    parameter int AW     = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wa_en,
    input  logic [AW-1:0]           wa_addr,
    input  logic [LANES-1:0]        wa_be,
    input  logic [LANES*LANE_W-1:0] wa_data,
    input  logic                    wb_en,
    input  logic [AW-1:0]           wb_addr,
    input  logic [LANES-1:0]        wb_be,
    input  logic [LANES*LANE_W-1:0] wb_data,
    input  logic [AW-1:0]           ra_addr,
    input  logic [AW-1:0]           rb_addr,
    output logic [LANES*LANE_W-1:0] ra_data,
    output logic [LANES*LANE_W-1:0] rb_data
);
    localparam int WW = LANES * LANE_W;

    logic [WW-1:0] mem [DEPTH];

    // Port B lanes are written first so a same-word, same-lane write from A lands last.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (wb_en && wb_be[i])
                mem[wb_addr][i*LANE_W +: LANE_W] <= wb_data[i*LANE_W +: LANE_W];
            if (wa_en && wa_be[i])
                mem[wa_addr][i*LANE_W +: LANE_W] <= wa_data[i*LANE_W +: LANE_W];
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/tpr_clash.sv
module tpr_clash #(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic             a_rd,
    input  logic             a_wr,
    input  logic [AW-1:0]    a_addr,
    input  logic [LANES-1:0] a_be,
    input  logic             b_rd,
    input  logic             b_wr,
    input  logic [AW-1:0]    b_addr,
    input  logic [LANES-1:0] b_be,
    output logic             a_hit,
    output logic             b_hit
);
    logic same_word;

    always_comb begin
        same_word = (a_addr == b_addr);
        a_hit     = a_rd && b_wr && (|b_be) && same_word;
        b_hit     = b_rd && a_wr && (|a_be) && same_word;
    end
endmodule

// File: rtl/tpr_port.sv
module tpr_port
    import twin_port_ram_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    wr,
    input  logic [LANES-1:0]        be,
    input  logic                    ce0_n,
    input  logic                    ce1,
    input  logic                    pipe,
    input  logic [LANES*LANE_W-1:0] arr_rdata,
    input  logic                    clash_hit,
    output logic                    acc_rd,
    output logic                    acc_wr,
    output logic [AW-1:0]           acc_addr,
    output logic [LANES-1:0]        acc_be,
    output logic [LANES*LANE_W-1:0] acc_wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid,
    output logic                    col_n
);
    localparam int WW = LANES * LANE_W;

    logic          sel;
    logic [WW-1:0] lane_masked;
    logic          s1_rd;
    logic [WW-1:0] s1_data;
    logic          s1_clash;
    logic [WW-1:0] s2_data;
    logic          s2_clash;
    rp_state_t     rp_state;
    rp_state_t     rp_next;

    assign sel = !ce0_n && ce1;

    // Input register stage: address, controls and data sampled on the rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_rd    <= 1'b0;
            acc_wr    <= 1'b0;
            acc_addr  <= '0;
            acc_be    <= '0;
            acc_wdata <= '0;
        end else begin
            acc_rd    <= sel && !wr;
            acc_wr    <= sel && wr;
            acc_addr  <= addr;
            acc_be    <= be;
            acc_wdata <= wdata;
        end
    end

    // Disabled lanes read back as zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_masked[g*LANE_W +: LANE_W] =
            acc_be[g] ? arr_rdata[g*LANE_W +: LANE_W] : '0;
    end

    // First read stage (flow-through output) and second stage (pipelined output).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_rd    <= 1'b0;
            s1_data  <= '0;
            s1_clash <= 1'b0;
            s2_data  <= '0;
            s2_clash <= 1'b0;
        end else begin
            s1_rd    <= acc_rd;
            s1_data  <= lane_masked;
            s1_clash <= acc_rd && clash_hit;
            s2_data  <= s1_data;
            s2_clash <= s1_clash;
        end
    end

    // State register of the pipelined output machine.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_state <= RP_IDLE;
        else        rp_state <= rp_next;
    end

    always_comb begin
        rp_next = RP_IDLE;
        unique case (rp_state)
            RP_IDLE: rp_next = s1_rd ? RP_LIVE : RP_IDLE;
            RP_LIVE: rp_next = s1_rd ? RP_LIVE : RP_TAIL;
            RP_TAIL: rp_next = s1_rd ? RP_LIVE : RP_IDLE;
            default: rp_next = RP_IDLE;
        endcase
    end

    // Output process.
    always_comb begin
        if (pipe) begin
            rvalid = (rp_state == RP_LIVE);
            rdata  = rvalid ? s2_data : '0;
            col_n  = !(rvalid && s2_clash);
        end else begin
            rvalid = s1_rd;
            rdata  = rvalid ? s1_data : '0;
            col_n  = !(rvalid && s1_clash);
        end
    end

    // R1
    desel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (!acc_rd && !acc_wr));

    // R4
    flow_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> (pipe || rvalid));

    // R5
    pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_rd, 2) && pipe) |-> rvalid);

    // R12
    write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_wr) && !pipe) |-> !rvalid);
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
    import twin_port_ram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic [35:0]   a_wdata,
    input  logic          a_wr,
    input  logic [3:0]    a_be,
    input  logic          a_ce0_n,
    input  logic          a_ce1,
    input  logic          a_pipe,
    output logic [35:0]   a_rdata,
    output logic          a_rvalid,
    output logic          a_col_n,
    input  logic [AW-1:0] b_addr,
    input  logic [35:0]   b_wdata,
    input  logic          b_wr,
    input  logic [3:0]    b_be,
    input  logic          b_ce0_n,
    input  logic          b_ce1,
    input  logic          b_pipe,
    output logic [35:0]   b_rdata,
    output logic          b_rvalid,
    output logic          b_col_n
);
    localparam int LANES = LANE_COUNT;
    localparam int LW    = LANE_BITS;
    localparam int WW    = LANES * LW;

    logic             pa_rd, pa_wr, pb_rd, pb_wr;
    logic [AW-1:0]    pa_addr, pb_addr;
    logic [LANES-1:0] pa_be, pb_be;
    logic [WW-1:0]    pa_wdata, pb_wdata;
    logic [WW-1:0]    arr_a, arr_b;
    logic             hit_a, hit_b;

    tpr_port #(.AW(AW), .LANES(LANES), .LANE_W(LW)) u_port_a (
        .clk(clk), .rst_n(rst_n), .addr(a_addr), .wdata(a_wdata), .wr(a_wr),
        .be(a_be), .ce0_n(a_ce0_n), .ce1(a_ce1), .pipe(a_pipe),
        .arr_rdata(arr_a), .clash_hit(hit_a),
        .acc_rd(pa_rd), .acc_wr(pa_wr), .acc_addr(pa_addr), .acc_be(pa_be),
        .acc_wdata(pa_wdata), .rdata(a_rdata), .rvalid(a_rvalid), .col_n(a_col_n)
    );

    tpr_port #(.AW(AW), .LANES(LANES), .LANE_W(LW)) u_port_b (
        .clk(clk), .rst_n(rst_n), .addr(b_addr), .wdata(b_wdata), .wr(b_wr),
        .be(b_be), .ce0_n(b_ce0_n), .ce1(b_ce1), .pipe(b_pipe),
        .arr_rdata(arr_b), .clash_hit(hit_b),
        .acc_rd(pb_rd), .acc_wr(pb_wr), .acc_addr(pb_addr), .acc_be(pb_be),
        .acc_wdata(pb_wdata), .rdata(b_rdata), .rvalid(b_rvalid), .col_n(b_col_n)
    );

    tpr_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LW)) u_array (
        .clk(clk),
        .wa_en(pa_wr), .wa_addr(pa_addr), .wa_be(pa_be), .wa_data(pa_wdata),
        .wb_en(pb_wr), .wb_addr(pb_addr), .wb_be(pb_be), .wb_data(pb_wdata),
        .ra_addr(pa_addr), .rb_addr(pb_addr), .ra_data(arr_a), .rb_data(arr_b)
    );

    tpr_clash #(.AW(AW), .LANES(LANES)) u_clash (
        .a_rd(pa_rd), .a_wr(pa_wr), .a_addr(pa_addr), .a_be(pa_be),
        .b_rd(pb_rd), .b_wr(pb_wr), .b_addr(pb_addr), .b_be(pb_be),
        .a_hit(hit_a), .b_hit(hit_b)
    );

    // R8
    a_alert_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_col_n |-> a_rvalid);

    // R8
    b_alert_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_col_n |-> b_rvalid);
endmodule

// File: tb/twin_port_ram_tb.sv
`timescale 1ns/1ps
module twin_port_ram_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  a_addr, b_addr;
    logic [35:0] a_wdata, b_wdata;
    logic        a_wr, b_wr;
    logic [3:0]  a_be, b_be;
    logic        a_ce0_n, a_ce1, b_ce0_n, b_ce1;
    logic        a_pipe, b_pipe;
    logic [35:0] a_rdata, b_rdata;
    logic        a_rvalid, b_rvalid, a_col_n, b_col_n;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    logic [35:0] model [256];

    always #2 clk = ~clk;

    twin_port_ram #(.DEPTH(256)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_wr(a_wr), .a_be(a_be),
        .a_ce0_n(a_ce0_n), .a_ce1(a_ce1), .a_pipe(a_pipe),
        .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_col_n(a_col_n),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_wr(b_wr), .b_be(b_be),
        .b_ce0_n(b_ce0_n), .b_ce1(b_ce1), .b_pipe(b_pipe),
        .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_col_n(b_col_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive_a(input bit sel, input bit wr, input logic [7:0] ad,
                           input logic [3:0] be, input logic [35:0] d);
        a_ce0_n = !sel; a_ce1 = sel; a_wr = wr; a_addr = ad; a_be = be; a_wdata = d;
    endtask

    task automatic drive_b(input bit sel, input bit wr, input logic [7:0] ad,
                           input logic [3:0] be, input logic [35:0] d);
        b_ce0_n = !sel; b_ce1 = sel; b_wr = wr; b_addr = ad; b_be = be; b_wdata = d;
    endtask

    task automatic idle_all();
        drive_a(0, 0, 0, 0, 0);
        drive_b(0, 0, 0, 0, 0);
    endtask

    function automatic logic [35:0] lanes(input logic [3:0] be, input logic [35:0] w);
        logic [35:0] r = '0;
        for (int i = 0; i < 4; i++) if (be[i]) r[i*9 +: 9] = w[i*9 +: 9];
        return r;
    endfunction

    task automatic model_write(input logic [7:0] ad, input logic [3:0] be, input logic [35:0] d);
        for (int i = 0; i < 4; i++) if (be[i]) model[ad][i*9 +: 9] = d[i*9 +: 9];
    endtask

    // One flow-through read on port A, checked after edge k+1.
    task automatic read_a_flow(input logic [7:0] ad, input logic [3:0] be, input string tag);
        a_pipe = 0;
        drive_a(1, 0, ad, be, 0);
        tick();
        drive_a(0, 0, 0, 0, 0);
        chk(a_rvalid == 0, {tag, " (R4 not after edge k)"}, 36'(a_rvalid), 0);
        tick();
        chk(a_rvalid == 1, {tag, " rvalid"}, 36'(a_rvalid), 1);
        chk(a_rdata == lanes(be, model[ad]), {tag, " data"}, a_rdata, lanes(be, model[ad]));
        tick();
        chk(a_rvalid == 0 && a_rdata == 0 && a_col_n == 1, "R10 idle outputs zero", a_rdata, 0);
    endtask

    task automatic t_reset();
        rst_n = 0; a_pipe = 0; b_pipe = 0;
        idle_all();
        repeat (4) tick();
        chk(a_rvalid == 0 && b_rvalid == 0, "R11 rvalid in reset", {34'd0, a_rvalid, b_rvalid}, 0);
        chk(a_col_n == 1 && b_col_n == 1, "R11 col_n in reset", {34'd0, a_col_n, b_col_n}, 36'h3);
        chk(a_rdata == 0 && b_rdata == 0, "R11 rdata in reset", a_rdata | b_rdata, 0);
        rst_n = 1;
        tick();
        chk(a_rvalid == 0 && b_rvalid == 0 && a_col_n && b_col_n, "R11 after release",
            {34'd0, a_rvalid, b_rvalid}, 0);
    endtask

    task automatic t_write_read();
        drive_a(1, 1, 3, 4'hF, 36'hA_BCDE_F012);
        model_write(3, 4'hF, 36'hA_BCDE_F012);
        tick();
        idle_all();
        tick();
        chk(a_rvalid == 0, "R12 write gives no rvalid", 36'(a_rvalid), 0);
        read_a_flow(3, 4'hF, "R2 R4 full word");
    endtask

    task automatic t_bytes();
        drive_a(1, 1, 3, 4'b0101, 36'h5_5555_5555);
        model_write(3, 4'b0101, 36'h5_5555_5555);
        tick();
        idle_all();
        tick();
        read_a_flow(3, 4'hF, "R2 lane merge");
        read_a_flow(3, 4'b0010, "R3 lane1 only");
    endtask

    task automatic t_pipe();
        b_pipe = 1;
        drive_b(1, 0, 3, 4'hF, 0);
        tick();
        drive_b(0, 0, 0, 0, 0);
        tick();
        chk(b_rvalid == 0, "R5 not after edge k+1", 36'(b_rvalid), 0);
        tick();
        chk(b_rvalid == 1 && b_rdata == model[3], "R5 data after edge k+2", b_rdata, model[3]);
        tick();
        chk(b_rvalid == 0 && b_rdata == 0, "R10 pipe idle", b_rdata, 0);
    endtask

    task automatic t_deselect_tail();
        b_pipe = 1;
        drive_b(1, 0, 3, 4'hF, 0);
        tick();
        // deselected through ce0_n while asking for a write: must be ignored (R1)
        b_ce0_n = 1; b_ce1 = 1; b_wr = 1; b_addr = 3; b_be = 4'hF; b_wdata = 36'hF_FFFF_FFFF;
        tick();
        b_ce0_n = 0; b_ce1 = 0; b_wr = 1;
        tick();
        chk(b_rvalid == 1 && b_rdata == model[3], "R6 in-flight read after deselect", b_rdata, model[3]);
        idle_all();
        tick();
        chk(b_rvalid == 0, "R6 rvalid falls after edge k+3", 36'(b_rvalid), 0);
        b_pipe = 0;
        tick();
        read_a_flow(3, 4'hF, "R1 deselected writes ignored");
    endtask

    task automatic t_same_read();
        a_pipe = 0; b_pipe = 0;
        drive_a(1, 0, 3, 4'hF, 0);
        drive_b(1, 0, 3, 4'hF, 0);
        tick();
        idle_all();
        tick();
        chk(a_rvalid && a_rdata == model[3], "R7 port A data", a_rdata, model[3]);
        chk(b_rvalid && b_rdata == model[3], "R7 port B data", b_rdata, model[3]);
        chk(a_col_n == 1 && b_col_n == 1, "R7 no alert", {34'd0, a_col_n, b_col_n}, 36'h3);
        tick();
    endtask

    task automatic t_clash_flow();
        a_pipe = 0; b_pipe = 0;
        drive_a(1, 1, 7, 4'hF, 36'h1_2345_6789);
        drive_b(1, 0, 7, 4'hF, 0);
        model_write(7, 4'hF, 36'h1_2345_6789);
        tick();
        idle_all();
        tick();
        chk(b_col_n == 0 && b_rvalid == 1, "R8 reader alert flow", {34'd0, b_col_n, b_rvalid}, 36'h1);
        chk(a_col_n == 1, "R8 writer no alert", 36'(a_col_n), 1);
        tick();
        chk(b_col_n == 1, "R10 alert clears", 36'(b_col_n), 1);
        // different addresses: no alert, B sees stored data
        drive_a(1, 1, 8, 4'hF, 36'h0_0000_0008);
        drive_b(1, 0, 7, 4'hF, 0);
        model_write(8, 4'hF, 36'h0_0000_0008);
        tick();
        idle_all();
        tick();
        chk(b_col_n == 1 && b_rdata == model[7], "R8 different word no alert", b_rdata, model[7]);
        tick();
    endtask

    task automatic t_clash_pipe();
        b_pipe = 1; a_pipe = 0;
        drive_a(1, 1, 7, 4'b0001, 36'h0_0000_0155);
        drive_b(1, 0, 7, 4'hF, 0);
        model_write(7, 4'b0001, 36'h0_0000_0155);
        tick();
        idle_all();
        tick();
        chk(b_col_n == 1 && b_rvalid == 0, "R8 pipe alert not early", {34'd0, b_col_n, b_rvalid}, 36'h2);
        tick();
        chk(b_col_n == 0 && b_rvalid == 1, "R8 pipe alert aligned", {34'd0, b_col_n, b_rvalid}, 36'h1);
        tick();
        b_pipe = 0;
        read_a_flow(7, 4'hF, "R8 write landed");
    endtask

    task automatic t_write_write();
        drive_a(1, 1, 9, 4'hF, 36'h0_AAAA_AAAA);
        drive_b(1, 1, 9, 4'hF, 36'h0_BBBB_BBBB);
        tick();
        idle_all();
        tick();
        chk(a_col_n == 1 && b_col_n == 1, "R9 no alert on dual write", {34'd0, a_col_n, b_col_n}, 36'h3);
        chk(a_rvalid == 0 && b_rvalid == 0, "R12 dual write no rvalid", {34'd0, a_rvalid, b_rvalid}, 0);
        tick();
    endtask

    task automatic t_cross();
        a_pipe = 0; b_pipe = 0;
        drive_a(1, 1, 20, 4'hF, 36'h7_0F0F_0F0F);
        model_write(20, 4'hF, 36'h7_0F0F_0F0F);
        tick();
        drive_a(0, 0, 0, 0, 0);
        drive_b(1, 0, 20, 4'hF, 0);
        tick();
        idle_all();
        tick();
        chk(b_rvalid && b_rdata == model[20] && b_col_n, "R13 cross-port fresh data", b_rdata, model[20]);
        tick();
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_bytes();
        t_pipe();
        t_deselect_tail();
        t_same_read();
        t_clash_flow();
        t_clash_pipe();
        t_write_write();
        t_cross();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=%h exp=%h", 36'd0, 36'd1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule